// File: doc/BRIEF.md
# Low-Leakage Stop Wakeup Controller

This block governs how a chip leaves its two low-leakage stop modes. In the shallow mode, logic state is retained, so a wake event simply returns the chip to normal operation and raises an interrupt request toward the CPU. In the deep mode, state is lost, so a wake event instead asks for a full system reset. It also records why the reset happened. The pads stay frozen under isolation until software acknowledges that the pin configuration has been restored.

Wake events come from external pins, each with its own two-bit edge selection, and from internal module interrupt lines, each gated by its own enable. One pin can also be routed through a digital glitch filter. The filter has its own wake flag, kept apart from the unfiltered one. The whole block runs on the slow low-power clock. Pins are brought in through a two-flop synchronizer. A dedicated reset pin forces an exit through a system reset from any mode. The reset-cause bits clear only on a power-on reset.

Top module: `llwake_ctrl`

## Requirements
- R1: A module interrupt line wakes the block only while its own bit in `mod_en` is 1. An active but disabled line leaves the block in its stop mode.
- R2: In the shallow mode, a wake event gives a one-cycle `wake_irq` pulse, no `reset_req`, and a return to normal operation.
- R3: In the deep mode, a wake event gives a one-cycle `reset_req` pulse, no `wake_irq`, and sets `cause_wakeup`.
- R4: `iso_hold` is 1 throughout the deep mode and after a deep-mode wake. It is released the cycle after `iso_ack` is sampled high. Outside the deep mode it is 0.
- R5: A low on `reset_pin_n` gives `reset_req` on the next cycle and sets `cause_pin`. If the block was in the deep mode, `cause_wakeup` is also set and `iso_hold` drops on that same next cycle.
- R6: If an enabled wake flag is already set when a stop mode is entered, the block exits again within a few cycles.
- R7: `filt_ready` stays 0 for INIT_CYC (5) low-power cycles after `filt_en` rises or after `filt_sel` changes, and is 1 once that count is done.
- R8: The filtered flag (`filt_flag`) and the unfiltered pin flags (`pin_flag`) are separate, and each is cleared only by writing 1 to its own clear input.
- R9: Each pin's field in `pin_edge` (bits 2i+1:2i) selects 00 off, 01 rising, 10 falling, 11 either edge. `filt_edge` uses the same code.
- R10: No flag is set while the block waits in the isolated state after a deep wake, including the cycle in which `iso_ack` releases it.
- R11: `stop_req` is honoured only in normal operation. `stop_deep` = 1 selects the deep mode and 0 the shallow mode.
- R12: `cause_wakeup` and `cause_pin` survive the block's own `reset_req` and clear only when `por_n` is low.
- R13: The filtered pin must hold a new level for FILT_LEN (3) consecutive cycles before the filter accepts it, so a one-cycle pulse sets no filtered flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lp_clk | input | 1 | Low-power clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wake_pin | input | NPIN | External wake pins |
| pin_edge | input | 2*NPIN | Edge select per pin |
| pin_flag_clr | input | NPIN | Write-one-to-clear for pin flags |
| pin_flag | output | NPIN | Unfiltered pin wake flags |
| mod_irq | input | NMOD | Internal module interrupt lines |
| mod_en | input | NMOD | Wake enable per module line |
| filt_en | input | 1 | Glitch filter enable |
| filt_sel | input | SELW | Pin routed to the filter |
| filt_edge | input | 2 | Edge select for the filtered pin |
| filt_flag_clr | input | 1 | Write-one-to-clear for the filtered flag |
| filt_flag | output | 1 | Filtered pin wake flag |
| filt_ready | output | 1 | Filter initialization finished |
| stop_req | input | 1 | Request to enter a stop mode |
| stop_deep | input | 1 | 1 = deep mode, 0 = shallow mode |
| reset_pin_n | input | 1 | External reset pin, active low |
| iso_ack | input | 1 | Software acknowledge that releases isolation |
| wake_irq | output | 1 | CPU interrupt request pulse |
| reset_req | output | 1 | System reset request |
| cause_wakeup | output | 1 | Reset cause: a low-leakage mode was active |
| cause_pin | output | 1 | Reset cause: the reset pin |
| iso_hold | output | 1 | Pad isolation hold |

## Verification
The assertions watch properties that must hold on every cycle. The interrupt and reset requests never coincide, and an interrupt only follows the shallow mode. A reset request always carries a cause bit, and cause bits never fall outside power-on reset. Isolation falls only after an acknowledge or a reset pin. No flag rises in the isolated state, and a stop mode is entered only from normal operation. The bench scenarios are needed for what depends on stimulus history: the edge-select codes against real pin waveforms, immediate exit on a stale flag, ignored disabled module lines, the filter's five-cycle initialization and glitch rejection, and the split between filtered and unfiltered flags.

// File: rtl/llwake_ctrl.sv
module llwake_ctrl #(
  parameter int NPIN = 4,
  parameter int NMOD = 4,
  parameter int INIT_CYC = 5,
  parameter int FILT_LEN = 3,
  localparam int SELW = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic            lp_clk,
  input  logic            por_n,
  input  logic [NPIN-1:0] wake_pin,
  input  logic [2*NPIN-1:0] pin_edge,
  input  logic [NPIN-1:0] pin_flag_clr,
  output logic [NPIN-1:0] pin_flag,
  input  logic [NMOD-1:0] mod_irq,
  input  logic [NMOD-1:0] mod_en,
  input  logic            filt_en,
  input  logic [SELW-1:0] filt_sel,
  input  logic [1:0]      filt_edge,
  input  logic            filt_flag_clr,
  output logic            filt_flag,
  output logic            filt_ready,
  input  logic            stop_req,
  input  logic            stop_deep,
  input  logic            reset_pin_n,
  input  logic            iso_ack,
  output logic            wake_irq,
  output logic            reset_req,
  output logic            cause_wakeup,
  output logic            cause_pin,
  output logic            iso_hold
);
  localparam int CWI = $clog2(INIT_CYC + 1);
  localparam int CWF = $clog2(FILT_LEN + 1);
  localparam logic [CWI-1:0] INIT_DONE = CWI'(INIT_CYC);
  localparam logic [CWF-1:0] FILT_LAST = CWF'(FILT_LEN - 1);

  typedef enum logic [1:0] {RUN, SHALLOW_STOP, DEEP_STOP, DEEP_EXIT_ISOLATED} mode_t;
  mode_t mode;

  logic [NPIN-1:0] sync1, sync2, hist, pin_hit, pin_on;
  logic [SELW-1:0] sel_q;
  logic [CWI-1:0]  init_cnt;
  logic [CWF-1:0]  stab_cnt;
  logic            filt_q, sel_bit, restart, filt_hit, freeze, wake_any;

  always_ff @(posedge lp_clk or negedge por_n)
    if (!por_n) begin
      sync1 <= '0; sync2 <= '0; hist <= '0;
    end else begin
      sync1 <= wake_pin; sync2 <= sync1; hist <= sync2;
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    wire [1:0] es = pin_edge[2*i +: 2];
    assign pin_hit[i] = (es[0] & sync2[i] & ~hist[i]) | (es[1] & ~sync2[i] & hist[i]);
    assign pin_on[i]  = |es;
  end

  assign freeze  = (mode == DEEP_EXIT_ISOLATED);
  assign sel_bit = sync2[filt_sel];
  assign restart = !filt_en || (filt_sel != sel_q);
  assign filt_ready = filt_en && !restart && (init_cnt == INIT_DONE);
  assign filt_hit = filt_ready && (sel_bit != filt_q) && (stab_cnt == FILT_LAST) &&
                    ((filt_edge[0] & sel_bit) | (filt_edge[1] & ~sel_bit));

  always_ff @(posedge lp_clk or negedge por_n)
    if (!por_n) begin
      sel_q <= '0; init_cnt <= '0; filt_q <= 1'b0; stab_cnt <= '0;
    end else begin
      sel_q <= filt_sel;
      if (restart) init_cnt <= '0;
      else if (init_cnt != INIT_DONE) init_cnt <= init_cnt + 1'b1;
      if (!filt_ready || sel_bit == filt_q) begin
        if (!filt_ready) filt_q <= sel_bit;
        stab_cnt <= '0;
      end else if (stab_cnt == FILT_LAST) begin
        filt_q <= sel_bit;
        stab_cnt <= '0;
      end else stab_cnt <= stab_cnt + 1'b1;
    end

  always_ff @(posedge lp_clk or negedge por_n)
    if (!por_n) begin
      pin_flag <= '0; filt_flag <= 1'b0;
    end else begin
      pin_flag  <= (pin_flag & ~pin_flag_clr) | (pin_hit & {NPIN{~freeze}});
      filt_flag <= (filt_flag & ~filt_flag_clr) | (filt_hit & ~freeze);
    end

  assign wake_any = |(pin_flag & pin_on) | (filt_flag & filt_en & |filt_edge) | |(mod_irq & mod_en);
  assign iso_hold = (mode == DEEP_STOP) || (mode == DEEP_EXIT_ISOLATED);

  always_ff @(posedge lp_clk or negedge por_n)
    if (!por_n) begin
      mode <= RUN; wake_irq <= 1'b0; reset_req <= 1'b0;
      cause_wakeup <= 1'b0; cause_pin <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      reset_req <= 1'b0;
      if (!reset_pin_n) begin
        reset_req <= 1'b1;
        cause_pin <= 1'b1;
        if (mode == DEEP_STOP) cause_wakeup <= 1'b1;
        mode <= RUN;
      end else begin
        case (mode)
          RUN:          if (stop_req) mode <= stop_deep ? DEEP_STOP : SHALLOW_STOP;
          SHALLOW_STOP: if (wake_any) begin wake_irq <= 1'b1; mode <= RUN; end
          DEEP_STOP:    if (wake_any) begin
                          reset_req <= 1'b1; cause_wakeup <= 1'b1; mode <= DEEP_EXIT_ISOLATED;
                        end
          DEEP_EXIT_ISOLATED: if (iso_ack) mode <= RUN;
        endcase
      end
    end

  assert_req_exclusive_R2: assert property (@(posedge lp_clk) disable iff (!por_n)
    !(wake_irq && reset_req));
  assert_irq_after_shallow_R2: assert property (@(posedge lp_clk) disable iff (!por_n)
    wake_irq |-> $past(mode == SHALLOW_STOP));
  assert_reset_has_cause_R3: assert property (@(posedge lp_clk) disable iff (!por_n)
    reset_req |-> (cause_wakeup || cause_pin));
  assert_iso_release_R4: assert property (@(posedge lp_clk) disable iff (!por_n)
    $fell(iso_hold) |-> $past(iso_ack || !reset_pin_n));
  assert_ready_stable_cfg_R7: assert property (@(posedge lp_clk) disable iff (!por_n)
    filt_ready |-> ($past(filt_en) && $past(filt_sel) == filt_sel));
  assert_no_flag_isolated_R10: assert property (@(posedge lp_clk) disable iff (!por_n)
    $past(mode == DEEP_EXIT_ISOLATED) |-> ((pin_flag & ~$past(pin_flag)) == '0 && !$rose(filt_flag)));
  assert_entry_from_run_R11: assert property (@(posedge lp_clk) disable iff (!por_n)
    (mode != $past(mode) && (mode == SHALLOW_STOP || mode == DEEP_STOP)) |-> $past(mode) == RUN);
  assert_cause_sticky_R12: assert property (@(posedge lp_clk) disable iff (!por_n)
    !$fell(cause_wakeup) && !$fell(cause_pin));
endmodule

// File: tb/llwake_ctrl_tb_top.sv
module llwake_ctrl_tb_top;
  localparam int NPIN = 4, NMOD = 4;
  logic clk = 1'b0, por_n = 1'b0;
  logic [NPIN-1:0] wake_pin = '0, pin_flag_clr = '0, pin_flag;
  logic [2*NPIN-1:0] pin_edge = '0;
  logic [NMOD-1:0] mod_irq = '0, mod_en = '0;
  logic filt_en = 1'b0, filt_flag_clr = 1'b0, filt_flag, filt_ready;
  logic [1:0] filt_sel = '0, filt_edge = '0;
  logic stop_req = 1'b0, stop_deep = 1'b0, reset_pin_n = 1'b1, iso_ack = 1'b0;
  logic wake_irq, reset_req, cause_wakeup, cause_pin, iso_hold;
  int checks = 0, fails = 0, irq_n = 0, rst_n = 0;

  always #2 clk = ~clk;

  llwake_ctrl dut_i (.lp_clk(clk), .por_n(por_n), .wake_pin(wake_pin), .pin_edge(pin_edge),
    .pin_flag_clr(pin_flag_clr), .pin_flag(pin_flag), .mod_irq(mod_irq), .mod_en(mod_en),
    .filt_en(filt_en), .filt_sel(filt_sel), .filt_edge(filt_edge), .filt_flag_clr(filt_flag_clr),
    .filt_flag(filt_flag), .filt_ready(filt_ready), .stop_req(stop_req), .stop_deep(stop_deep),
    .reset_pin_n(reset_pin_n), .iso_ack(iso_ack), .wake_irq(wake_irq), .reset_req(reset_req),
    .cause_wakeup(cause_wakeup), .cause_pin(cause_pin), .iso_hold(iso_hold));

  always @(negedge clk) begin
    if (wake_irq) irq_n++;
    if (reset_req) rst_n++;
  end

  // row: [6] expect wake, [5] deep, [4:3] pin, [2:1] edge code, [0] 1 = rising stimulus
  localparam logic [6:0] ROWS [7] = '{7'b1_0_00_01_1, 7'b1_0_01_10_0, 7'b0_0_10_01_0,
                                      7'b1_1_11_11_1, 7'b0_1_00_00_1, 7'b1_1_10_10_0,
                                      7'b1_0_11_11_0};

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask
  task automatic enter(bit deep);
    stop_deep = deep; stop_req = 1'b1; cyc(1); stop_req = 1'b0;
  endtask
  task automatic ack();
    iso_ack = 1'b1; cyc(1); iso_ack = 1'b0;
  endtask
  task automatic clr_all();
    pin_flag_clr = '1; filt_flag_clr = 1'b1; cyc(1); pin_flag_clr = '0; filt_flag_clr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int i0, r0;
    cyc(3); por_n = 1'b1; cyc(1);
    chk("reset iso_hold", iso_hold, 0);
    chk("reset cause_wakeup R12", cause_wakeup, 0);
    chk("reset pin_flag", pin_flag, 0);
    chk("reset filt_ready R7", filt_ready, 0);
    chk("reset reset_req", reset_req, 0);

    // R5: reset pin during deep mode
    enter(1'b1); cyc(2);
    chk("deep iso_hold R4", iso_hold, 1);
    reset_pin_n = 1'b0; cyc(1); reset_pin_n = 1'b1;
    chk("R5 reset_req", reset_req, 1);
    chk("R5 iso drops at once", iso_hold, 0);
    chk("R5 cause_pin", cause_pin, 1);
    chk("R5 cause_wakeup", cause_wakeup, 1);
    cyc(2);

    for (int r = 0; r < 7; r++) begin
      logic [6:0] row;
      int p;
      row = ROWS[r]; p = int'(row[4:3]);
      pin_edge = '0; wake_pin[p] = ~row[0]; cyc(4); clr_all();
      pin_edge[2*p +: 2] = row[2:1];
      enter(row[5]); cyc(2);
      i0 = irq_n; r0 = rst_n;
      wake_pin[p] = row[0]; cyc(8);
      chk($sformatf("R9 row %0d pin_flag", r), pin_flag[p], row[6]);
      if (row[5]) begin
        chk($sformatf("R3 row %0d reset_req", r), rst_n - r0, row[6]);
        chk($sformatf("R3 row %0d no irq", r), irq_n - i0, 0);
        chk($sformatf("R4 row %0d iso held", r), iso_hold, 1);
      end else begin
        chk($sformatf("R2 row %0d wake_irq", r), irq_n - i0, row[6]);
        chk($sformatf("R2 row %0d no reset", r), rst_n - r0, 0);
      end
      if (!row[6]) begin mod_en[0] = 1'b1; mod_irq[0] = 1'b1; cyc(4); mod_irq = '0; mod_en = '0; end
      if (row[5]) ack();
      cyc(2);
      chk($sformatf("R4 row %0d iso released", r), iso_hold, 0);
      pin_edge = '0; wake_pin[p] = 1'b0; cyc(4); clr_all();
    end
    chk("R12 cause kept through own reset", cause_wakeup, 1);

    // R1: disabled module line ignored, then enabled
    i0 = irq_n;
    mod_irq[1] = 1'b1; enter(1'b0); cyc(6);
    chk("R1 disabled module no wake", irq_n - i0, 0);
    mod_en[1] = 1'b1; cyc(4);
    chk("R1 enabled module wakes", irq_n - i0, 1);
    mod_irq = '0; mod_en = '0; cyc(2);

    // R6: stale flag causes immediate exit
    pin_edge[1:0] = 2'b01; wake_pin[0] = 1'b1; cyc(5);
    chk("R6 flag pending", pin_flag[0], 1);
    i0 = irq_n; enter(1'b0); cyc(4);
    chk("R6 immediate exit", irq_n - i0, 1);
    pin_edge = '0; wake_pin = '0; cyc(4); clr_all();

    // R11 and R10 inside the isolated state
    r0 = rst_n; i0 = irq_n;
    mod_en[2] = 1'b1; mod_irq[2] = 1'b1; enter(1'b1); cyc(4);
    chk("R3 module deep wake", rst_n - r0, 1);
    enter(1'b0); cyc(4);
    chk("R11 entry ignored when isolated", irq_n - i0, 0);
    chk("R11 still isolated", iso_hold, 1);
    mod_irq = '0; mod_en = '0;
    pin_edge[3:2] = 2'b11; wake_pin[1] = 1'b1; cyc(5);
    chk("R10 no flag while isolated", pin_flag[1], 0);
    ack(); cyc(4);
    chk("R10 no flag on release", pin_flag[1], 0);
    wake_pin[1] = 1'b0; cyc(5);
    chk("R10 flag after release", pin_flag[1], 1);
    pin_edge = '0; cyc(1); clr_all();

    // R7: filter initialization
    filt_sel = 2'd2; filt_edge = 2'b01; filt_en = 1'b1; cyc(3);
    chk("R7 not ready early", filt_ready, 0);
    cyc(3);
    chk("R7 ready after count", filt_ready, 1);
    filt_sel = 2'd3; cyc(1);
    chk("R7 sel change restarts", filt_ready, 0);
    cyc(6);
    chk("R7 ready again", filt_ready, 1);

    // R13 / R8: glitch rejection and separate flags
    pin_edge[7:6] = 2'b01;
    wake_pin[3] = 1'b1; cyc(1); wake_pin[3] = 1'b0; cyc(6);
    chk("R13 glitch rejected", filt_flag, 0);
    chk("R8 unfiltered flag set by glitch", pin_flag[3], 1);
    pin_flag_clr[3] = 1'b1; cyc(1); pin_flag_clr = '0;
    wake_pin[3] = 1'b1; cyc(7);
    chk("R13 long pulse accepted", filt_flag, 1);
    filt_flag_clr = 1'b1; cyc(1); filt_flag_clr = 1'b0;
    chk("R8 filt flag cleared", filt_flag, 0);
    chk("R8 pin flag kept", pin_flag[3], 1);
    wake_pin[3] = 1'b0; cyc(7);
    chk("R9 filter rising-only ignores fall", filt_flag, 0);
    pin_edge = '0; clr_all();
    i0 = irq_n; enter(1'b0); cyc(2);
    wake_pin[3] = 1'b1; cyc(9);
    chk("R2 filtered pin wakes shallow", irq_n - i0, 1);
    wake_pin = '0; filt_en = 1'b0; cyc(4); clr_all();

    // R12: power-on reset clears causes; R5 reset pin outside deep
    por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(1);
    chk("R12 POR clears cause_wakeup", cause_wakeup, 0);
    chk("R12 POR clears cause_pin", cause_pin, 0);
    reset_pin_n = 1'b0; cyc(1); reset_pin_n = 1'b1; cyc(1);
    chk("R5 pin reset in run cause_pin", cause_pin, 1);
    chk("R5 pin reset in run no wake cause", cause_wakeup, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule